// File: doc/BRIEF.md
# Tributary Multiframe Phase Tracker

This block follows the four-frame tributary multiframe carried inside a high-order virtual container. The multiframe lasts 500 µs, one frame per 125 µs. The phase of the multiframe comes from the path overhead byte that marks the position. Its two least significant bits count 0, 1, 2, 3 across successive frames and then wrap. The six upper bits are fixed at 1. Each phase matches one tributary pointer byte: phase 0 goes with V1, phase 1 with V2, phase 2 with V3 and phase 3 with V4.

On the receive side the block takes one marker byte per frame, each qualified by a strobe. A four-state machine runs the loss and recovery rules. While locked it flywheels, advancing its own phase one step per frame. On the transmit side a counter produces the marker byte sequence. A mode input chooses which side drives the phase output and the pointer-byte select.

Top module: `mfi_tracker`

## Requirements
- R1: After reset: `mf_loss` is 1, `phase` is 0, `vsel` is 4'b0001 and `tx_byte` is 8'hFC.
- R2: `tx_byte` has bits [7:2] all 1 and bits [1:0] equal to the transmit count. Each cycle with `tx_strobe` high advances the count by one, and 3 wraps to 0. Without `tx_strobe` the count holds.
- R3: While `mf_loss` is 1, two consecutive receive strobes whose values satisfy second = first+1 (mod 4) clear `mf_loss` in the cycle after the second strobe. The receive phase then equals the second value.
- R4: While locked, each receive strobe advances the receive phase by one (mod 4), whatever value is received, unless that strobe declares loss.
- R5: A single out-of-sequence value while locked does not set `mf_loss`. If the next value equals the flywheel phase +1, the tracker stays locked.
- R6: Two consecutive out-of-sequence values while locked set `mf_loss` in the cycle after the second one. The receive phase then takes the second received value.
- R7: Bits [7:2] of `rx_byte` have no effect. Only bits [1:0] are compared.
- R8: `vsel` is one-hot, and bit i is set when `phase` equals i (bit 0 is V1 through bit 3 is V4).
- R9: When `tx_mode` is 1, `phase` and `vsel` follow the transmit count. When `tx_mode` is 0, they follow the receive phase.
- R10: In cycles without `rx_strobe`, the receive phase and `mf_loss` hold.

States: ST_HUNT means no value has been taken yet, and loss is flagged. ST_PEND means one candidate value is held, and loss is flagged. ST_LOCK means aligned. ST_SLIP means one miss has been seen while aligned, and loss is not yet flagged.

Transitions on each `rx_strobe`, where e is the held phase + 1:
- HUNT goes to PEND.
- PEND goes to LOCK when the received value equals e. Otherwise it stays in PEND.
- LOCK stays in LOCK on a match and goes to SLIP on a miss.
- SLIP goes to LOCK on a match and goes to PEND on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_strobe | input | 1 | Qualifies `rx_byte`, one per frame |
| rx_byte | input | 8 | Received multiframe marker byte |
| tx_strobe | input | 1 | Advances the transmit count, one per frame |
| tx_mode | input | 1 | 1: outputs follow the transmit count, 0: they follow the receive tracker |
| tx_byte | output | 8 | Generated marker byte |
| phase | output | 2 | Current multiframe phase |
| vsel | output | 4 | One-hot pointer byte select, V1 to V4 |
| mf_loss | output | 1 | Loss of multiframe alignment |

## Verification
A receive strobe and a transmit strobe can fall in the same cycle. When `tx_mode` is 1, this means the displayed phase moves while the receive tracker is also changing state underneath it. The bench drives both strobes together in many cycles and toggles `tx_mode` between frames. A behavioural model tracks the two sides separately, and every output is compared against it on every clock. The bench also provokes a second miss arriving in the same cycle as a transmit advance. This confirms that loss declaration and transmit counting do not disturb each other.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
    localparam int MF_LEN = 4;
    localparam int PH_W   = $clog2(MF_LEN);
    localparam int BYTE_W = 8;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PEND,
        ST_LOCK,
        ST_SLIP
    } rx_state_t;
endpackage

// File: rtl/mfi_rx_fsm.sv
module mfi_rx_fsm
    import mfi_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [BW-1:0] rx_byte,
    output phase_t        rx_phase,
    output logic          loss
);
    rx_state_t state_q, state_d;
    phase_t    phase_q, phase_d;
    phase_t    rcv, nxt;
    logic      match;

    assign rcv   = rx_byte[PH_W-1:0];
    assign nxt   = phase_q + phase_t'(1);
    assign match = (rcv == nxt);

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        if (strobe) begin
            unique case (state_q)
                ST_HUNT: begin
                    state_d = ST_PEND;
                    phase_d = rcv;
                end
                ST_PEND: begin
                    state_d = match ? ST_LOCK : ST_PEND;
                    phase_d = rcv;
                end
                ST_LOCK: begin
                    state_d = match ? ST_LOCK : ST_SLIP;
                    phase_d = nxt;
                end
                ST_SLIP: begin
                    state_d = match ? ST_LOCK : ST_PEND;
                    phase_d = rcv;
                end
                default: begin
                    state_d = ST_HUNT;
                    phase_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        rx_phase = phase_q;
        unique case (state_q)
            ST_HUNT, ST_PEND: loss = 1'b1;
            ST_LOCK, ST_SLIP: loss = 1'b0;
            default:          loss = 1'b1;
        endcase
    end
endmodule

// File: rtl/mfi_tx_gen.sv
module mfi_tx_gen
    import mfi_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    output phase_t        tx_phase,
    output logic [BW-1:0] tx_byte
);
    localparam int RSV_W = BW - PH_W;

    phase_t cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (strobe) cnt_q <= cnt_q + phase_t'(1);
    end

    assign tx_phase = cnt_q;
    assign tx_byte  = {{RSV_W{1'b1}}, cnt_q};
endmodule

// File: rtl/mfi_tracker.sv
module mfi_tracker
    import mfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_strobe,
    input  logic              tx_mode,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [PH_W-1:0]   phase,
    output logic [MF_LEN-1:0] vsel,
    output logic              mf_loss
);
    phase_t rx_ph, tx_ph;

    mfi_rx_fsm #(.BW(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (rx_strobe),
        .rx_byte  (rx_byte),
        .rx_phase (rx_ph),
        .loss     (mf_loss)
    );

    mfi_tx_gen #(.BW(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (tx_strobe),
        .tx_phase (tx_ph),
        .tx_byte  (tx_byte)
    );

    assign phase = tx_mode ? tx_ph : rx_ph;

    for (genvar i = 0; i < MF_LEN; i++) begin : g_vsel
        assign vsel[i] = (phase == phase_t'(i));
    end
endmodule

// File: rtl/mfi_tracker_chk.sv
module mfi_tracker_chk
    import mfi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_strobe,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              tx_strobe,
    input logic              tx_mode,
    input logic [BYTE_W-1:0] tx_byte,
    input logic [PH_W-1:0]   phase,
    input logic [MF_LEN-1:0] vsel,
    input logic              mf_loss
);
    AST_TX_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte[BYTE_W-1:PH_W] == '1); // R2

    AST_TX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> tx_byte[PH_W-1:0] == PH_W'($past(tx_byte[PH_W-1:0]) + 1)); // R2

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_strobe |=> $stable(tx_byte)); // R2

    AST_VSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(vsel)); // R8

    AST_VSEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        vsel[phase]); // R8

    AST_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> $stable(mf_loss)); // R10

    AST_LOSS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_loss) |-> $past(rx_strobe)); // R6

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !tx_mode && !mf_loss &&
         rx_byte[PH_W-1:0] == PH_W'(phase + 1)) |=> !mf_loss); // R5
endmodule

bind mfi_tracker mfi_tracker_chk u_chk (.*);

// File: tb/tb_mfi_tracker.sv
module tb_mfi_tracker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_strobe = 1'b0;
    logic       tx_mode = 1'b0;
    logic [7:0] tx_byte;
    logic [1:0] phase;
    logic [3:0] vsel;
    logic       mf_loss;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model
    int m_locked = 0, m_have = 0, m_miss = 0, m_ph = 0, m_tx = 0, m_mode = 0;

    mfi_tracker dut (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .tx_strobe(tx_strobe), .tx_mode(tx_mode), .tx_byte(tx_byte),
        .phase(phase), .vsel(vsel), .mf_loss(mf_loss)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int eph;
        eph = m_mode ? m_tx : m_ph;
        chk(mf_loss == (m_locked == 0), "R1 R3 R5 R6 R10 mf_loss", int'(mf_loss), int'(m_locked == 0));
        chk(int'(phase) == eph, "R4 R7 R9 phase", int'(phase), eph);
        chk(int'(vsel) == (1 << eph), "R8 vsel", int'(vsel), 1 << eph);
        chk(int'(tx_byte) == (8'hFC | m_tx), "R2 tx_byte", int'(tx_byte), 8'hFC | m_tx);
    endtask

    function automatic void model_rx(input int r);
        int e;
        e = (m_ph + 1) % 4;
        if (m_locked != 0) begin
            if (r == e) begin
                m_miss = 0;
                m_ph = e;
            end else begin
                m_miss++;
                if (m_miss == 2) begin
                    m_locked = 0;
                    m_ph = r;
                    m_have = 1;
                end else begin
                    m_ph = e;
                end
            end
        end else begin
            if (m_have != 0 && r == e) begin
                m_locked = 1;
                m_miss = 0;
            end
            m_ph = r;
            m_have = 1;
        end
    endfunction

    // compare current outputs, then apply inputs for the next edge
    task automatic step(input bit rs, input int rv, input bit ts, input bit md);
        @(negedge clk);
        compare_all();
        rx_strobe = rs;
        rx_byte   = 8'(rv);
        tx_strobe = ts;
        tx_mode   = md;
        m_mode    = md;
        if (rs) model_rx(rv % 4);
        if (ts) m_tx = (m_tx + 1) % 4;
    endtask

    // reserved bits deliberately noisy (R7)
    function automatic int noisy(input int v);
        return (($urandom % 64) << 2) | v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mf_loss == 1'b1, "R1 loss", int'(mf_loss), 1);
        chk(phase == 2'd0, "R1 phase", int'(phase), 0);
        chk(vsel == 4'b0001, "R1 vsel", int'(vsel), 1);
        chk(tx_byte == 8'hFC, "R1 tx_byte", int'(tx_byte), 252);

        // R3 acquire with clean bytes
        step(1, 8'hFE, 0, 0);
        step(1, 8'hFF, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 8'hFC | ((i) % 4), 0, 0);
        // R10 idle cycles
        for (int i = 0; i < 5; i++) step(0, 8'h01, 0, 0);
        // R5 single miss then back in sequence
        step(1, 8'hFC | ((m_ph + 2) % 4), 0, 0);
        step(1, 8'hFC | ((m_ph + 1) % 4), 0, 0);
        step(1, 8'hFC | ((m_ph + 1) % 4), 0, 0);
        // R6 two misses declare loss
        step(1, 8'hFC | ((m_ph + 3) % 4), 0, 0);
        step(1, 8'hFC | ((m_ph + 3) % 4), 0, 0);
        step(0, 0, 0, 0);
        // R3 false candidate then real recovery
        step(1, 8'hFC | ((m_ph + 2) % 4), 0, 0);
        step(1, 8'hFC | ((m_ph + 1) % 4), 0, 0);
        step(0, 0, 0, 0);
        // R7 noisy reserved bits in sequence
        for (int i = 0; i < 12; i++) step(1, noisy((m_ph + 1) % 4), 0, 0);
        // R2 R9 transmit mode
        for (int i = 0; i < 10; i++) step(0, 0, 1, 1);
        step(0, 0, 0, 1);
        // same-cycle rx and tx strobes, mode toggling
        for (int i = 0; i < 40; i++) begin
            int v;
            v = (($urandom % 4) == 0) ? ($urandom % 4) : (m_ph + 1) % 4;
            step(($urandom % 3) != 0, noisy(v), ($urandom % 2) == 1, (i / 5) % 2 == 1);
        end
        // second miss coincides with tx advance
        step(1, noisy((m_ph + 1) % 4), 0, 1);
        step(1, noisy((m_ph + 1) % 4), 0, 1);
        step(1, noisy((m_ph + 3) % 4), 1, 1);
        step(1, noisy((m_ph + 3) % 4), 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        @(negedge clk);
        compare_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule